// File: doc/BRIEF.md
# Long-Press Dual-Button Reset Timer

This block turns a deliberate, long two-button hold into a system reset request. Two active-low button lines are synchronised into the clock domain. The block counts only while both lines are low together. Counting uses a free timebase tick, first through a prescaler that makes a base period and then through a counter of base periods. When the count reaches the selected delay, both reset outputs assert at the same moment. They stay asserted until either button is let go. Letting go of either button early, before the delay has run, clears the count and leaves the outputs untouched. Brief accidental presses therefore never reset the system.

A static strap level selects the delay, short or long, in a 2:3 ratio. The level is captured when counting starts and is held until the count returns to idle. There are two outputs. One is an enable for an external open-drain pull-down: 1 means pull the reset line low, and 0 means release it. The other is an active-high push-pull reset level. All terminal counts are parameters, so a simulation can use small values.

Top module: `lp_reset_timer`

## Requirements
- R1: After reset, `rst_sink_en` is 0 (line released) and `rst_out` is 0.
- R2: With only one button line low, no number of ticks asserts either output.
- R3: Releasing either button before the delay is reached leaves both outputs at 0 and clears the count. A new press needs the full delay again.
- R4: With `dly_long` = 0, the outputs assert on the edge that samples the (2·UNIT·PRE_DIV)-th tick counted while both buttons are held, and not one tick earlier.
- R5: With `dly_long` = 1, the outputs assert on the (3·UNIT·PRE_DIV)-th counted tick, and not one tick earlier.
- R6: `rst_sink_en` and `rst_out` always carry the same value, so both assert and deassert in the same cycle.
- R7: Once asserted, the outputs stay asserted while both buttons remain held, however many further ticks arrive.
- R8: Releasing either button while the outputs are asserted deasserts both within three clock cycles, two for synchronisation and one for the state update. The next press needs the full delay again.
- R9: `dly_long` is captured when counting begins. A change during counting has no effect on the delay in progress.
- R10: The count advances only on cycles with `tick` = 1. Clock cycles without a tick never bring the outputs closer to asserting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick | input | 1 | Single-cycle timebase pulse |
| btn_a_n | input | 1 | First button line, active low, asynchronous |
| btn_b_n | input | 1 | Second button line, active low, asynchronous |
| dly_long | input | 1 | Static strap: 0 short delay, 1 long delay |
| rst_sink_en | output | 1 | Open-drain enable: 1 pulls the reset line low |
| rst_out | output | 1 | Active-high reset level |

## Verification
The bench holds a single button against a long run of ticks, which separates a one-input trigger from the required two-input condition. It then runs a press that is released one tick short, followed by a fresh press. This shows whether a release really clears the count or only pauses it. Full presses with each strap value are checked one tick before the terminal count and at the terminal count, which pins the exact ratio of the delays. A press with no ticks, a strap change during a count, and a single-button release after firing separate tick gating, strap capture and the release path.

// File: rtl/lpr_pkg.sv
package lpr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_FIRED = 2'd2
    } lpr_state_e;

    typedef struct packed {
        logic run;    // advance the counters on a tick
        logic clear;  // hold both counter stages at zero
    } lpr_ctl_t;

    // base periods needed for the selected delay (2:3 ratio)
    function automatic int unsigned bases_for(input logic long_sel, input int unsigned unit);
        return long_sel ? 3 * unit : 2 * unit;
    endfunction

endpackage

// File: rtl/lpr_sync.sv
module lpr_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    // per-line two-flop synchroniser, resets to released (high)
    for (genvar i = 0; i < W; i++) begin : g_line
        logic meta, stab;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta <= 1'b1;
                stab <= 1'b1;
            end else begin
                meta <= d_async[i];
                stab <= meta;
            end
        end
        assign q_sync[i] = stab;
    end
endmodule

// File: rtl/lpr_prescale.sv
module lpr_prescale #(
    parameter int PRE_DIV = 1250
) (
    input  logic                clk,
    input  logic                rst,
    input  lpr_pkg::lpr_ctl_t   ctl,
    input  logic                tick,
    output logic                base_stb
);
    if (PRE_DIV <= 1) begin : g_direct
        assign base_stb = ctl.run & tick;
    end else begin : g_div
        localparam int PW = $clog2(PRE_DIV);
        localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);
        logic [PW-1:0] cnt;
        always_ff @(posedge clk) begin
            if (rst || ctl.clear) begin
                cnt <= '0;
            end else if (ctl.run && tick) begin
                cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            end
        end
        assign base_stb = ctl.run & tick & (cnt == LAST);
    end
endmodule

// File: rtl/lpr_basecnt.sv
module lpr_basecnt #(
    parameter int UNIT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  lpr_pkg::lpr_ctl_t ctl,
    input  logic              base_stb,
    input  logic              long_sel,
    output logic              done
);
    localparam int BW = $clog2(3 * UNIT + 1);
    logic [BW-1:0] cnt;
    logic [BW-1:0] last;

    assign last = BW'(lpr_pkg::bases_for(long_sel, UNIT) - 1);

    always_ff @(posedge clk) begin
        if (rst || ctl.clear) begin
            cnt <= '0;
        end else if (base_stb && !done) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = base_stb & (cnt == last);
endmodule

// File: rtl/lpr_ctrl.sv
module lpr_ctrl (
    input  logic              clk,
    input  logic              rst,
    input  logic              both_held,
    input  logic              sel_in,
    input  logic              done,
    output lpr_pkg::lpr_ctl_t ctl,
    output logic              sel_q,
    output logic              fired
);
    import lpr_pkg::*;
    lpr_state_e state, nxt;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:  if (both_held) nxt = ST_COUNT;
            ST_COUNT: if (!both_held) nxt = ST_IDLE;
                      else if (done) nxt = ST_FIRED;
            ST_FIRED: if (!both_held) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            sel_q <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && both_held) sel_q <= sel_in;
        end
    end

    assign ctl.run   = (state == ST_COUNT) && both_held;
    assign ctl.clear = (state != ST_COUNT);
    assign fired     = (state == ST_FIRED);
endmodule

// File: rtl/lp_reset_timer.sv
module lp_reset_timer #(
    parameter int PRE_DIV = 1250,
    parameter int UNIT    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic btn_a_n,
    input  logic btn_b_n,
    input  logic dly_long,
    output logic rst_sink_en,
    output logic rst_out
);
    logic [1:0]        btn_s;
    logic              both_held;
    logic              sel_q, base_stb, done, fired;
    lpr_pkg::lpr_ctl_t ctl;

    lpr_sync #(.W(2)) i_sync (
        .clk(clk), .rst(rst), .d_async({btn_b_n, btn_a_n}), .q_sync(btn_s)
    );

    assign both_held = ~btn_s[0] & ~btn_s[1];

    lpr_ctrl i_ctrl (
        .clk(clk), .rst(rst), .both_held(both_held), .sel_in(dly_long),
        .done(done), .ctl(ctl), .sel_q(sel_q), .fired(fired)
    );

    lpr_prescale #(.PRE_DIV(PRE_DIV)) i_pre (
        .clk(clk), .rst(rst), .ctl(ctl), .tick(tick), .base_stb(base_stb)
    );

    lpr_basecnt #(.UNIT(UNIT)) i_base (
        .clk(clk), .rst(rst), .ctl(ctl), .base_stb(base_stb),
        .long_sel(sel_q), .done(done)
    );

    assign rst_sink_en = fired;
    assign rst_out     = fired;
endmodule

// File: rtl/lpr_checker.sv
module lpr_checker (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic both_held,
    input logic rst_out
);
    // R2: assertion only ever follows a cycle with both buttons held
    assert_fire_needs_both_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_out) |-> $past(both_held));

    // R10: assertion only ever follows a tick
    assert_fire_needs_tick_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_out) |-> $past(tick));

    // R7: held buttons keep the reset asserted
    assert_hold_while_pressed_R7: assert property (@(posedge clk) disable iff (rst)
        (rst_out && both_held) |=> rst_out);

    // R8: a released button drops the reset on the next state update
    assert_release_drops_R8: assert property (@(posedge clk) disable iff (rst)
        (rst_out && !both_held) |=> !rst_out);
endmodule

bind lp_reset_timer lpr_checker i_lpr_checker (
    .clk(clk), .rst(rst), .tick(tick), .both_held(both_held), .rst_out(rst_out)
);

// File: tb/test_lp_reset_timer.sv
module test_lp_reset_timer;
    localparam int PRE_DIV = 4;
    localparam int UNIT    = 2;
    localparam int N_SHORT = 2 * UNIT * PRE_DIV;
    localparam int N_LONG  = 3 * UNIT * PRE_DIV;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic btn_a_n = 1'b1;
    logic btn_b_n = 1'b1;
    logic dly_long = 1'b0;
    logic rst_sink_en, rst_out;
    int   n_chk = 0;
    int   n_bad = 0;

    always #5 clk = ~clk;

    lp_reset_timer #(.PRE_DIV(PRE_DIV), .UNIT(UNIT)) i_lp_reset_timer (
        .clk(clk), .rst(rst), .tick(tick), .btn_a_n(btn_a_n), .btn_b_n(btn_b_n),
        .dly_long(dly_long), .rst_sink_en(rst_sink_en), .rst_out(rst_out)
    );

    task automatic chk(input string req, input logic exp);
        n_chk++;
        if (rst_out !== exp || rst_sink_en !== exp) begin
            n_bad++;
            $display("FAIL %s: rst_out=%b rst_sink_en=%b expected %b", req, rst_out, rst_sink_en, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic press();
        btn_a_n = 1'b0;
        btn_b_n = 1'b0;
        cyc(4);
    endtask

    task automatic release_all();
        btn_a_n = 1'b1;
        btn_b_n = 1'b1;
        cyc(5);
    endtask

    task automatic t_reset();
        chk("R1 reset state", 1'b0);
    endtask

    task automatic t_single();
        btn_a_n = 1'b0;
        cyc(4);
        ticks(N_LONG + 5);
        chk("R2 single button held", 1'b0);
        release_all();
    endtask

    task automatic t_no_tick();
        press();
        cyc(60);
        chk("R10 no ticks", 1'b0);
        ticks(N_SHORT - 1);
        chk("R10 ticks only counted", 1'b0);
        ticks(1);
        chk("R10 terminal tick", 1'b1);
        release_all();
    endtask

    task automatic t_short_press();
        dly_long = 1'b0;
        press();
        ticks(N_SHORT - 1);
        release_all();
        chk("R3 early release no change", 1'b0);
        press();
        ticks(N_SHORT - 1);
        chk("R3 count cleared by release", 1'b0);
        ticks(1);
        chk("R4 short delay reached", 1'b1);
        release_all();
    endtask

    task automatic t_long_hold_release();
        dly_long = 1'b1;
        cyc(2);
        press();
        ticks(N_LONG - 1);
        chk("R5 one tick before long delay", 1'b0);
        ticks(1);
        chk("R5 long delay reached", 1'b1);
        chk("R6 outputs agree on assert", 1'b1);
        ticks(30);
        chk("R7 held after extra ticks", 1'b1);
        btn_b_n = 1'b1;
        cyc(1);
        chk("R8 still asserted during sync", 1'b1);
        cyc(3);
        chk("R8 deasserted after release", 1'b0);
        chk("R6 outputs agree on release", 1'b0);
        btn_b_n = 1'b0;
        cyc(4);
        ticks(N_LONG - 1);
        chk("R8 full delay needed again", 1'b0);
        ticks(1);
        chk("R8 refire after full delay", 1'b1);
        release_all();
        dly_long = 1'b0;
        cyc(2);
    endtask

    task automatic t_sel_change();
        dly_long = 1'b0;
        press();
        ticks(5);
        dly_long = 1'b1;
        ticks(N_SHORT - 6);
        chk("R9 before captured short delay", 1'b0);
        ticks(1);
        chk("R9 captured short delay used", 1'b1);
        release_all();
        dly_long = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        t_reset();
        t_single();
        t_no_tick();
        t_short_press();
        t_long_hold_release();
        t_sel_change();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule